// File: doc/BRIEF.md
# Toggle-Handshake Elastic Queue

This block is a short first-in first-out buffer that sits between two pipeline stages which run at their own, changing rates. Each side hands words over with a two-phase handshake. A request is an edge on a `go` line, and the reply is an edge on the matching `ack` line. The levels on these lines carry no meaning; only a difference between them does. A transaction is open while `go` and `ack` differ, and the reply makes them equal again.

The queue is a chain of `DEPTH` registers. A word enters at the head and moves one register per clock toward the tail whenever the next register is free, or is being freed on that same edge. A word at the tail is offered to the consumer. When the producer runs ahead, the queue absorbs the surplus. Once every register is occupied, the producer's request stays open until the consumer takes a word. An occupancy count reports how many words are held.

Top module: `elastic_queue`

## Requirements
- R1: An enqueue is pending whenever `in_go` differs from `in_ack`. If the head register can take a word on a clock edge, the queue stores `in_data` on that edge and toggles `in_ack` exactly once. `in_ack` never changes while no enqueue is pending.
- R2: While all `DEPTH` registers hold words and the tail word is not being taken, `in_ack` holds still. A pending enqueue completes on the same edge on which the consumer's acknowledgement frees the tail.
- R3: `out_go` toggles once on each edge that loads a word into the tail register. While `out_go` differs from `out_ack`, `out_data` holds that word. Toggling `out_ack` to equal `out_go` removes the word on the next edge.
- R4: Words leave in the order in which they were accepted, with no loss and no duplication.
- R5: Into an empty queue, a request present before edge e is accepted at e, and `out_go` toggles at edge e+DEPTH-1. Each register adds one clock hop.
- R6: `occupancy` equals the number of words held, 0 to `DEPTH`, and changes by at most one per edge.
- R7: After reset, `occupancy` is 0 and both `in_ack` and `out_go` are 0.
- R8: `DEPTH` values 1, 2 and 3 behave as above. An enqueue and a dequeue on the same edge leave `occupancy` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_go | input | 1 | Producer request toggle |
| in_data | input | WIDTH | Word offered by the producer |
| in_ack | output | 1 | Enqueue completion toggle |
| out_go | output | 1 | Word-available toggle to the consumer |
| out_data | output | WIDTH | Word at the tail |
| out_ack | input | 1 | Consumer completion toggle |
| occupancy | output | $clog2(DEPTH+1) | Number of words held |

## Verification
The collision that matters is an enqueue and a dequeue landing on the same edge. The most delicate case is a full queue, where the free space exists only because the tail is leaving. The bench provokes this for every depth. It fills the queue, leaves a further request open for several cycles, and then toggles `out_ack`. It then expects `in_ack` to answer on that very edge while `occupancy` stays at `DEPTH`. Randomised-looking producer and consumer gating patterns repeat the collision mid-stream, and the bench judges each cycle by comparing `occupancy` with accepted minus taken words and by checking the word order.

// File: rtl/elastic_queue.sv
module elastic_queue #(
  parameter int DEPTH = 2,
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_go,
  input  logic [WIDTH-1:0]           in_data,
  output logic                       in_ack,
  output logic                       out_go,
  output logic [WIDTH-1:0]           out_data,
  input  logic                       out_ack,
  output logic [$clog2(DEPTH+1)-1:0] occupancy
);
  localparam int CW = $clog2(DEPTH+1);

  logic [DEPTH-1:0] full;
  logic [DEPTH-1:0] move;
  logic [DEPTH:0]   load;
  logic [WIDTH-1:0] slot  [DEPTH];
  logic [WIDTH-1:0] stage [DEPTH+1];
  logic             room0;

  wire pend_in  = in_go != in_ack;
  wire drop     = full[DEPTH-1] && (out_go == out_ack);
  wire take     = pend_in && room0;

  always_comb begin
    room0 = drop || ((~full) != '0);
    for (int i = 0; i < DEPTH; i++)
      move[i] = full[i] && (drop || (((~full) >> (i + 1)) != '0));
    load = {move, take};
    stage[0] = in_data;
    for (int i = 0; i < DEPTH; i++)
      stage[i+1] = slot[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= '0;
      in_ack <= 1'b0;
      out_go <= 1'b0;
    end else begin
      if (take) in_ack <= ~in_ack;
      if (load[DEPTH-1]) out_go <= ~out_go;
      for (int i = 0; i < DEPTH; i++)
        full[i] <= (full[i] && !move[i]) || load[i];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++)
      if (load[i]) slot[i] <= stage[i];
  end

  assign out_data  = slot[DEPTH-1];
  assign occupancy = CW'($countones(full));

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_ack) |-> $past(in_go) != $past(in_ack)); // R1
  AST_FULL_HOLDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (&full && !drop) |=> $stable(in_ack)); // R2
  AST_GO_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_go) |-> ($past(out_go) == $past(out_ack)) || !$past(full[DEPTH-1])); // R3
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_go != out_ack) && $past(out_go != out_ack)) |-> $stable(out_data)); // R3
  AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occupancy) <= int'($past(occupancy)) + 1) &&
    (int'(occupancy) + 1 >= int'($past(occupancy)))); // R6
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0) |-> (out_go == out_ack)); // R6
endmodule

// File: tb/sim_elastic_queue.sv
`timescale 1ns/1ps
module sim_elastic_queue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] igo = '0;
  logic [2:0] oack = '0;
  logic [7:0] idat [3];
  wire  [2:0] iack;
  wire  [2:0] ogo;
  wire  [7:0] odat [3];
  wire  [1:0] occ  [3];
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < 3; g++) begin : gq
    wire [$clog2(g+2)-1:0] oc;
    elastic_queue #(.DEPTH(g+1), .WIDTH(8)) u0 (
      .clk(clk), .rst_n(rst_n),
      .in_go(igo[g]), .in_data(idat[g]), .in_ack(iack[g]),
      .out_go(ogo[g]), .out_data(odat[g]), .out_ack(oack[g]),
      .occupancy(oc));
    assign occ[g] = 2'(oc);
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_depth(int g);
    int d;
    int n;
    int acc;
    int popped;
    int sent;
    int rcv;
    logic prev;
    logic [7:0] base;
    d = g + 1;
    base = 8'(g * 64);
    // R5: latency through an empty queue
    idat[g] = base;
    igo[g] = ~igo[g];
    step();
    check(iack[g] == igo[g], "R1", int'(iack[g]), int'(igo[g]));
    check(occ[g] == 1, "R6", int'(occ[g]), 1);
    n = 1;
    while (ogo[g] == oack[g] && n < 10) begin
      step();
      n++;
    end
    check(n == d, "R5", n, d);
    check(odat[g] == base, "R3", int'(odat[g]), int'(base));
    oack[g] = ~oack[g];
    step();
    check(occ[g] == 0, "R6", int'(occ[g]), 0);
    // fill to capacity
    for (int k = 0; k < d; k++) begin
      idat[g] = base + 8'(1 + k);
      igo[g] = ~igo[g];
      n = 0;
      do begin
        step();
        n++;
      end while (iack[g] != igo[g] && n < 10);
      check(iack[g] == igo[g], "R1", int'(iack[g]), int'(igo[g]));
    end
    repeat (d) step();
    check(occ[g] == d, "R6", int'(occ[g]), d);
    check(ogo[g] != oack[g], "R3", int'(ogo[g]), int'(~oack[g]));
    check(odat[g] == base + 8'd1, "R4", int'(odat[g]), int'(base) + 1);
    // R2: request against a full queue stays open
    idat[g] = base + 8'(1 + d);
    igo[g] = ~igo[g];
    repeat (4) step();
    check(iack[g] != igo[g], "R2", int'(iack[g]), int'(~igo[g]));
    check(occ[g] == d, "R2", int'(occ[g]), d);
    check(odat[g] == base + 8'd1, "R3", int'(odat[g]), int'(base) + 1);
    // R8: dequeue and enqueue collide on one edge
    oack[g] = ~oack[g];
    step();
    check(iack[g] == igo[g], "R2", int'(iack[g]), int'(igo[g]));
    check(occ[g] == d, "R8", int'(occ[g]), d);
    for (int k = 2; k <= d + 1; k++) begin
      n = 0;
      while (ogo[g] == oack[g] && n < 10) begin
        step();
        n++;
      end
      check(odat[g] == base + 8'(k), "R4", int'(odat[g]), int'(base) + k);
      oack[g] = ~oack[g];
      step();
    end
    check(occ[g] == 0, "R6", int'(occ[g]), 0);
    // streaming with uneven rates
    acc = 0; popped = 0; sent = 0; rcv = 0;
    prev = iack[g];
    for (int cyc = 0; cyc < 200 && (rcv < 25); cyc++) begin
      if (iack[g] != prev) begin
        acc++;
        prev = iack[g];
      end
      check(int'(occ[g]) == acc - popped, "R6", int'(occ[g]), acc - popped);
      check(int'(occ[g]) <= d, "R8", int'(occ[g]), d);
      if (ogo[g] != oack[g] && (cyc > 90 || (cyc % 7) < 3)) begin
        check(odat[g] == base + 8'(16 + rcv), "R4", int'(odat[g]), int'(base) + 16 + rcv);
        oack[g] = ~oack[g];
        popped++;
        rcv++;
      end
      if (igo[g] == iack[g] && sent < 25 && ((cyc * 7 + g) % 5) != 0) begin
        idat[g] = base + 8'(16 + sent);
        igo[g] = ~igo[g];
        sent++;
      end
      step();
    end
    check(rcv == 25, "R4", rcv, 25);
    step();
    check(occ[g] == 0, "R6", int'(occ[g]), 0);
  endtask

  initial begin
    for (int g = 0; g < 3; g++) idat[g] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int g = 0; g < 3; g++) begin
      check(occ[g] == 0, "R7", int'(occ[g]), 0);
      check(iack[g] == 1'b0, "R7", int'(iack[g]), 0);
      check(ogo[g] == 1'b0, "R7", int'(ogo[g]), 0);
    end
    rst_n = 1'b1;
    step();
    for (int g = 0; g < 3; g++) run_depth(g);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule